// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared state of a multi-channel event timer: a free-running main count, a configuration word with a run bit, a write-one-to-clear status word fed by the comparator channels, and a read-only capability word. Software reaches all of it through a 64-bit register window. The window accepts 8-byte accesses and 4-byte accesses to either half of a register.

The count advances by one on each cycle where the single-cycle `tick_en` input is high and the run bit is set. This keeps the tick rate independent of the system clock. The current count and the run state are driven straight out to the comparator channels. A one-cycle re-arm pulse tells the channels to recompute their deadlines.

Every request gets a response one cycle later. Accesses of an illegal size or alignment are dropped without effect and read as zero.

Register window, byte offsets: 0x00 capabilities, 0x08 configuration, 0x10 status, 0x18 main count. Any other offset is unmapped.

Top module: `evt_glob_regs`

## Requirements
- R1: Only accesses with `req_size` equal to 4 or 8 (byte count) are legal; a write of any other size changes no register, and a read of any other size returns zero.
- R2: An access whose byte offset is not a multiple of its size is dropped: a write changes nothing and a read returns zero.
- R3: A 4-byte access with address bit 2 set addresses bits 63:32 of the register, and one with bit 2 clear addresses bits 31:0. A write changes only the addressed half. A read returns that half in bits 31:0 of `rsp_rdata`, with bits 63:32 zero.
- R4: The capability word reads as: revision 1 in bits 7:0; channel count minus one in bits 12:8; bit 13 clear (32-bit counter); vendor ID in bits 31:16; and integer 10^15 / 2^TICK_LOG2 (tick period in femtoseconds) in bits 63:32. Writes to it have no effect.
- R5: While the run bit is set, the count increases by one for each cycle with `tick_en` high, wrapping from 2^32-1 to 0. While the run bit is clear the count holds, and it resumes from the held value when the run bit is set again.
- R6: Configuration bit 0 is the run bit. Bit 1 (legacy interrupt routing) and every other bit always read as zero, whatever is written.
- R7: A write to the main count merges the written half into the zero-extended current count and loads the low 32 bits of the result. A write to the upper half therefore leaves the count unchanged. A write takes precedence over a tick in the same cycle.
- R8: `rearm` is high for exactly the one cycle after either of two writes: a write to the main count while the run bit is set, or a configuration write that sets a clear run bit. It stays low after a count write made while the run bit is clear.
- R9: A write to the status register clears exactly those bits that are set and written as 1. A bit raised on `sts_set` in the same cycle stays set. Status bits occupy bits NUM_CH-1:0, and `sts_o` shows them.
- R10: A read of an unmapped offset returns zero.
- R11: `rsp_valid` is high in the cycle after each request. After reset, the count, the configuration and the status all read zero, and `rearm` and `cnt_enabled` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance strobe, one cycle per tick |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, right-aligned for 4-byte accesses |
| sts_set | input | NUM_CH | Per-channel status set pulses |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data |
| cnt_value | output | CNT_W | Current main count |
| cnt_enabled | output | 1 | Run bit |
| rearm | output | 1 | One-cycle pulse to re-arm the comparator channels |
| sts_o | output | NUM_CH | Status bits |

## Verification
The assertions assume that `req_size`, `req_addr` and `req_valid` are known in every cycle after reset, and that the request fields are held stable only for the one cycle in which `req_valid` is high. They also assume that `sts_set` pulses mark real channel events, which may coincide with a clearing write. The bench drives every input at the falling edge, raises `req_valid` for a single cycle per access, and keeps `tick_en` low except inside explicit tick bursts. As a result, every read of the count sees a value that the bench can predict from the tick bursts it has issued.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAPS,
    SEL_CFG,
    SEL_STS,
    SEL_CNT
  } reg_sel_e;

  typedef struct packed {
    logic        rd;
    logic        wr;
    reg_sel_e    sel;
    logic        half;
    logic        hi;
    logic [63:0] mask;
    logic [63:0] data;
  } acc_t;

  function automatic logic size_legal(input logic [3:0] sz);
    return (sz == 4'd4) || (sz == 4'd8);
  endfunction

  function automatic logic offset_aligned(input logic [2:0] lo, input logic [3:0] sz);
    if (sz == 4'd8) return lo == 3'b000;
    return lo[1:0] == 2'b00;
  endfunction

  function automatic logic [63:0] lane_mask(input logic half, input logic hi);
    if (!half) return '1;
    return hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
  endfunction

  function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                          input logic [63:0] new_v,
                                          input logic [63:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [31:0] tick_fs(input int unsigned log2_rate);
    logic [63:0] q;
    q = 64'd1000000000000000 / (64'd1 << log2_rate);
    return q[31:0];
  endfunction

  function automatic logic [63:0] cap_word(input int unsigned nch,
                                           input logic [15:0] vid,
                                           input int unsigned log2_rate);
    logic [4:0] n1;
    n1 = 5'(nch - 1);
    return {tick_fs(log2_rate), vid, 3'b000, n1, 8'd1};
  endfunction

endpackage

// File: rtl/evt_access_decode.sv
module evt_access_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output acc_t              acc,
  output logic              legal
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             half;
  logic             hi;

  assign idx   = req_addr[ADDR_W-1:3];
  assign legal = size_legal(req_size) && offset_aligned(req_addr[2:0], req_size);
  assign half  = (req_size == 4'd4);
  assign hi    = half && req_addr[2];

  always_comb begin
    acc      = '0;
    acc.rd   = req_valid && !req_write && legal;
    acc.wr   = req_valid &&  req_write && legal;
    acc.half = half;
    acc.hi   = hi;
    acc.mask = lane_mask(half, hi);
    acc.data = hi ? {req_wdata[31:0], 32'h0} : req_wdata;
    case (idx)
      IDX_W'(0): acc.sel = SEL_CAPS;
      IDX_W'(1): acc.sel = SEL_CFG;
      IDX_W'(2): acc.sel = SEL_STS;
      IDX_W'(3): acc.sel = SEL_CNT;
      default:   acc.sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_mask,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt_q
);
  logic             step;
  logic [CNT_W-1:0] load_val;

  assign step     = run && tick_en;
  assign load_val = (cnt_q & ~ld_mask) | (ld_data & ld_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld_en) cnt_q <= load_val;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !ld_en) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_en) |=> $stable(cnt_q));

  assert_upper_write_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_mask == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_status_w1c.sv
module evt_status_w1c #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_en,
  input  logic [NUM_CH-1:0] clr_bits,
  output logic [NUM_CH-1:0] sts_q
);
  logic [NUM_CH-1:0] clr_eff;

  assign clr_eff = clr_en ? (clr_bits & sts_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_eff) | set_i;
  end

  assert_no_spurious_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(set_i)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~sts_q) == '0));

  assert_only_written_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> (($past(sts_q) & ~sts_q) == '0));

endmodule

// File: rtl/evt_glob_regs.sv
module evt_glob_regs
  import evt_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          CNT_W     = 32,
  parameter int          NUM_CH    = 8,
  parameter int          TICK_LOG2 = 24,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [NUM_CH-1:0] sts_set,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              cnt_enabled,
  output logic              rearm,
  output logic [NUM_CH-1:0] sts_o
);
  localparam logic [63:0] CAPS = cap_word(NUM_CH, VENDOR_ID, TICK_LOG2);

  acc_t        acc;
  logic        legal;
  logic        en_q;
  logic        cfg_wr;
  logic        cnt_wr;
  logic        sts_wr;
  logic        en_next;
  logic        rearm_q;
  logic [63:0] cfg_view;
  logic [63:0] merged_cfg;
  logic [63:0] full_val;
  logic [63:0] rd_val;

  evt_access_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .acc       (acc),
    .legal     (legal)
  );

  assign cfg_wr = acc.wr && (acc.sel == SEL_CFG);
  assign cnt_wr = acc.wr && (acc.sel == SEL_CNT);
  assign sts_wr = acc.wr && (acc.sel == SEL_STS);

  assign cfg_view   = {63'b0, en_q};
  assign merged_cfg = merge64(cfg_view, acc.data, acc.mask);
  assign en_next    = merged_cfg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (cfg_wr) en_q <= en_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rearm_q <= 1'b0;
    else        rearm_q <= (cnt_wr && en_q) || (cfg_wr && !en_q && en_next);
  end

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .tick_en (tick_en),
    .ld_en   (cnt_wr),
    .ld_mask (acc.mask[CNT_W-1:0]),
    .ld_data (acc.data[CNT_W-1:0]),
    .cnt_q   (cnt_value)
  );

  evt_status_w1c #(.NUM_CH(NUM_CH)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (sts_set),
    .clr_en   (sts_wr),
    .clr_bits (acc.data[NUM_CH-1:0] & acc.mask[NUM_CH-1:0]),
    .sts_q    (sts_o)
  );

  always_comb begin
    case (acc.sel)
      SEL_CAPS: full_val = CAPS;
      SEL_CFG:  full_val = cfg_view;
      SEL_STS:  full_val = 64'(sts_o);
      SEL_CNT:  full_val = 64'(cnt_value);
      default:  full_val = '0;
    endcase
    if (!acc.half)   rd_val = full_val;
    else if (acc.hi) rd_val = {32'h0, full_val[63:32]};
    else             rd_val = {32'h0, full_val[31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= acc.rd ? rd_val : '0;
    end
  end

  assign cnt_enabled = en_q;
  assign rearm       = rearm_q;

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid)));

  assert_legacy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd && acc.sel == SEL_CFG) |=> (rsp_rdata[63:1] == '0));

  assert_illegal_write_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !legal) |=> ($stable(en_q) && !rearm_q));

  assert_illegal_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !legal) |=> (rsp_rdata == '0));

  assert_rearm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_q && !$past(req_valid)) |-> 1'b0);

endmodule

// File: tb/evt_glob_regs_tb.sv
module evt_glob_regs_tb;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [NCH-1:0] sts_set = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [31:0] cnt_value;
  logic        cnt_enabled;
  logic        rearm;
  logic [NCH-1:0] sts_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] rd;
  logic        rearm_seen;
  logic        rv_seen;

  always #10 clk = ~clk;

  evt_glob_regs u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .sts_set(sts_set),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cnt_value(cnt_value),
    .cnt_enabled(cnt_enabled), .rearm(rearm), .sts_o(sts_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [3:0] sz,
                      input logic [63:0] d, input logic [NCH-1:0] setb);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    sts_set = setb;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; sts_set = '0;
    rd = rsp_rdata; rearm_seen = rearm; rv_seen = rsp_valid;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    xfer(0, 8'h18, 8, 0, 0); chk("R11 count after reset", rd, 0);
    chk("R11 rsp_valid", {63'b0, rv_seen}, 1);
    xfer(0, 8'h08, 8, 0, 0); chk("R11 config after reset", rd, 0);
    xfer(0, 8'h10, 8, 0, 0); chk("R11 status after reset", rd, 0);
    chk("R11 enable low", {63'b0, cnt_enabled}, 0);
    chk("R11 rearm low", {63'b0, rearm_seen}, 0);
  endtask

  task automatic t_caps;
    logic [63:0] exp;
    exp = {32'(64'd1000000000000000 >> 24), 16'hA5C3, 16'h0701};
    xfer(0, 8'h00, 8, 0, 0); chk("R4 caps 64-bit", rd, exp);
    xfer(0, 8'h00, 4, 0, 0); chk("R3 caps low half", rd, {32'h0, exp[31:0]});
    xfer(0, 8'h04, 4, 0, 0); chk("R3 caps high half", rd, {32'h0, exp[63:32]});
    xfer(1, 8'h00, 8, 64'h0, 0);
    xfer(0, 8'h00, 8, 0, 0); chk("R4 caps write ignored", rd, exp);
  endtask

  task automatic t_illegal;
    xfer(1, 8'h08, 2, 64'h1, 0);
    chk("R1 size-2 write dropped", {63'b0, cnt_enabled}, 0);
    xfer(0, 8'h00, 1, 0, 0); chk("R1 size-1 read zero", rd, 0);
    xfer(0, 8'h04, 8, 0, 0); chk("R2 misaligned 8-byte read zero", rd, 0);
    xfer(1, 8'h0A, 4, 64'h1, 0);
    chk("R2 misaligned write dropped", {63'b0, cnt_enabled}, 0);
    xfer(0, 8'h20, 8, 0, 0); chk("R10 unmapped 0x20", rd, 0);
    xfer(0, 8'hF8, 8, 0, 0); chk("R10 unmapped 0xF8", rd, 0);
  endtask

  task automatic t_config;
    xfer(1, 8'h08, 8, 64'h3, 0);
    chk("R8 rearm on enable", {63'b0, rearm_seen}, 1);
    xfer(0, 8'h08, 8, 0, 0); chk("R6 legacy bit reads zero", rd, 64'h1);
    chk("R6 enable out", {63'b0, cnt_enabled}, 1);
    chk("R8 rearm one cycle", {63'b0, rearm_seen}, 0);
    xfer(1, 8'h0C, 4, 64'hFFFF_FFFF, 0);
    xfer(0, 8'h08, 8, 0, 0); chk("R3 upper config write keeps low half", rd, 64'h1);
  endtask

  task automatic t_count;
    logic [63:0] c0;
    xfer(0, 8'h18, 8, 0, 0); c0 = rd;
    ticks(5);
    xfer(0, 8'h18, 8, 0, 0); chk("R5 five ticks", rd, c0 + 5);
    xfer(1, 8'h08, 4, 64'h0, 0);
    ticks(4);
    xfer(0, 8'h18, 8, 0, 0); chk("R5 frozen while disabled", rd, c0 + 5);
    xfer(1, 8'h08, 4, 64'h1, 0);
    ticks(3);
    xfer(0, 8'h18, 8, 0, 0); chk("R5 resumes", rd, c0 + 8);
  endtask

  task automatic t_cnt_write;
    xfer(1, 8'h18, 4, 64'h1234_5678, 0);
    chk("R8 rearm on count write", {63'b0, rearm_seen}, 1);
    xfer(0, 8'h18, 8, 0, 0); chk("R7 count loaded", rd, 64'h1234_5678);
    xfer(1, 8'h1C, 4, 64'hDEAD, 0);
    xfer(0, 8'h18, 8, 0, 0); chk("R7 upper write no effect", rd, 64'h1234_5678);
    xfer(0, 8'h1C, 4, 0, 0); chk("R3 count upper half zero", rd, 0);
    xfer(1, 8'h18, 8, 64'hAAAA_BBBB_FFFF_FFFE, 0);
    xfer(0, 8'h18, 8, 0, 0); chk("R7 8-byte load truncated", rd, 64'hFFFF_FFFE);
    ticks(3);
    xfer(0, 8'h18, 8, 0, 0); chk("R5 wrap", rd, 64'h1);
    @(negedge clk); tick_en = 1'b1;
    xfer(1, 8'h18, 4, 64'h100, 0);
    tick_en = 1'b0;
    xfer(0, 8'h18, 8, 0, 0); chk("R7 write beats tick", rd, 64'h100);
    xfer(1, 8'h08, 8, 64'h0, 0);
    xfer(1, 8'h18, 4, 64'h50, 0);
    chk("R8 no rearm when disabled", {63'b0, rearm_seen}, 0);
  endtask

  task automatic t_status;
    xfer(0, 8'h20, 8, 0, 8'hA5);
    xfer(0, 8'h10, 8, 0, 0); chk("R9 status set", rd, 64'hA5);
    xfer(1, 8'h10, 8, 64'h0F, 0);
    xfer(0, 8'h10, 8, 0, 0); chk("R9 w1c clears set bits only", rd, 64'hA0);
    xfer(1, 8'h10, 8, 64'h0, 0);
    xfer(0, 8'h10, 8, 0, 0); chk("R9 zero write no effect", rd, 64'hA0);
    xfer(1, 8'h10, 8, 64'h80, 8'h80);
    chk("R9 set wins over clear", {56'b0, sts_o}, 64'hA0);
    xfer(1, 8'h14, 4, 64'hFF, 0);
    chk("R3 upper status write no clear", {56'b0, sts_o}, 64'hA0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_caps;
    t_illegal;
    t_config;
    t_count;
    t_cnt_write;
    t_status;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule